// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer

This block watches a service line driven by software and raises a one-cycle expiry strobe when no service transition arrives within the selected timeout. The strobe goes to a reset generator. While that generator holds the system in reset, it reports this back on `sys_rst_active`, and the timer stays at zero until the reset ends. With the mode input low, the timeout is the programmed base count. With the mode input high, the timeout is the base count multiplied by `MULT`, which defaults to 500. A base count of zero switches the whole function off.

In extended mode the block produces an internal service pulse a little before expiry. The pulse sits at the extended timeout minus one sixteenth of it. When the service pad is reported as floating, this pulse replaces the pad level. The pulse goes high for one cycle and then back low, so the timer is cleared twice and never expires. In normal mode the internal drive is off, and a floating pad gives no protection against expiry. The raw service input passes through a two-flop synchronizer, and edges are detected on the synchronized level.

Top module: `wdog_dualmode`

## Requirements
- R1: With `mode_ext` low and `base_cnt` = B > 0, the timeout is B cycles. If `sys_rst_active` is released at a falling clock edge and the service input stays quiet, `expire` is first high just after the B-th rising edge that follows.
- R2: With `mode_ext` high and `base_cnt` = B > 0, the timeout is `MULT`×B cycles. With the default `MULT`, that is 500×B cycles.
- R3: A rising edge on `svc_in` clears the timer to zero, and so does a falling edge. The input passes through two synchronizer flops and one edge-detect cycle. A toggle applied between rising edges therefore gives `expire` just after the (T+3)-th rising edge that follows, where T is the timeout.
- R4: Any change in the level of `mode_ext` clears the timer on the next rising edge. The timer then counts toward the timeout of the new mode.
- R5: While `sys_rst_active` is high, the timer is held at zero and `expire` stays low. After release, counting starts again from zero.
- R6: When `base_cnt` is zero, neither `expire` nor `svc_drive` is ever asserted.
- R7: `expire` is exactly one cycle wide. After an expiry the counter stays at the timeout, so no second strobe appears until a clear (service edge, mode change or reset).
- R8: In extended mode `svc_drive` pulses high for exactly one cycle. The pulse comes just after rising edge S, counted from the clear, where S = T − floor(T/16). It appears whether or not the pad is floating.
- R9: In extended mode with `svc_float` high, the pad level is replaced by `svc_drive`, so `expire` never asserts. After release the first pulse comes at edge S, and later pulses follow every S+2 edges.
- R10: In normal mode `svc_drive` stays low. With `svc_float` high, `expire` still comes after B cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block itself |
| svc_in | input | 1 | Raw service input from the pad |
| svc_float | input | 1 | High when the service pad is detected as undriven |
| mode_ext | input | 1 | 0 selects the base timeout, 1 selects the base timeout × MULT |
| base_cnt | input | BASE_W | Base timeout in clock cycles; 0 disables the watchdog |
| sys_rst_active | input | 1 | High while the reset generator holds the system in reset |
| expire | output | 1 | One-cycle strobe when the timeout is reached |
| svc_drive | output | 1 | Internal self-service pulse (extended mode only) |

## Verification
The bench builds the block with `BASE_W` = 4 and keeps `MULT` at 500. This makes every normal-mode base value from 1 to 15 cheap to sweep one by one. The extended timeouts of 500 and 1000 cycles, and the self-service pulse at cycle 469, also become short enough to measure to the exact cycle. The same small width lets the bench cover the zero-base case and toggle the service and mode inputs part-way through a period in a few thousand cycles.

// File: rtl/wdog_dualmode.sv
module wdog_dualmode #(
  parameter int BASE_W = 16,
  parameter int MULT   = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_in,
  input  logic              svc_float,
  input  logic              mode_ext,
  input  logic [BASE_W-1:0] base_cnt,
  input  logic              sys_rst_active,
  output logic              expire,
  output logic              svc_drive
);

  localparam int CNT_W = BASE_W + $clog2(MULT);

  logic             s1, s2, eff_q, mode_q;
  logic [CNT_W-1:0] cnt;

  wire             en      = (base_cnt != '0);
  wire [CNT_W-1:0] tmo     = mode_ext ? CNT_W'(base_cnt) * CNT_W'(MULT) : CNT_W'(base_cnt);
  wire [CNT_W-1:0] self_pt = tmo - (tmo >> 4);
  wire             eff     = (mode_ext && svc_float) ? svc_drive : s2;
  wire             clr     = sys_rst_active | ~en | (eff ^ eff_q) | (mode_ext ^ mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      eff_q     <= 1'b0;
      mode_q    <= 1'b0;
      cnt       <= '0;
      expire    <= 1'b0;
      svc_drive <= 1'b0;
    end else begin
      s1        <= svc_in;
      s2        <= s1;
      eff_q     <= eff;
      mode_q    <= mode_ext;
      if (clr)
        cnt <= '0;
      else if (cnt < tmo)
        cnt <= cnt + 1'b1;
      expire    <= !clr && (cnt == tmo - 1'b1);
      svc_drive <= !clr && mode_ext && (cnt == self_pt - 1'b1);
    end
  end

endmodule

module wdog_dualmode_chk #(
  parameter int BASE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_ext,
  input logic [BASE_W-1:0] base_cnt,
  input logic              sys_rst_active,
  input logic              expire,
  input logic              svc_drive
);

  p_rst_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_active |=> !expire);

  p_zero_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (base_cnt == '0) |=> (!expire && !svc_drive));

  p_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  p_drive_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_drive |=> !svc_drive);

  p_drive_off_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ext |=> !svc_drive);

endmodule

bind wdog_dualmode wdog_dualmode_chk #(.BASE_W(BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .base_cnt(base_cnt),
  .sys_rst_active(sys_rst_active), .expire(expire), .svc_drive(svc_drive)
);

// File: tb/tb_wdog_dualmode.sv
`timescale 1ns/1ps
module tb_wdog_dualmode;
  localparam int BW   = 4;
  localparam int MULT = 500;

  logic clk = 1'b0, rst_n = 1'b0;
  logic svc_in = 1'b0, svc_float = 1'b0, mode_ext = 1'b0, sys_rst_active = 1'b1;
  logic [BW-1:0] base_cnt = '0;
  logic expire, svc_drive;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  wdog_dualmode #(.BASE_W(BW), .MULT(MULT)) dut (
    .clk(clk), .rst_n(rst_n), .svc_in(svc_in), .svc_float(svc_float),
    .mode_ext(mode_ext), .base_cnt(base_cnt), .sys_rst_active(sys_rst_active),
    .expire(expire), .svc_drive(svc_drive));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_sig(input bit drv, input int limit, output int n);
    n = 0;
    while (n <= limit) begin
      @(posedge clk); #1; n++;
      if (drv ? svc_drive : expire) break;
    end
  endtask

  task automatic count_sig(input bit drv, input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (drv ? svc_drive : expire) hits++;
    end
  endtask

  task automatic start(input int b, input bit m, input bit f);
    @(negedge clk);
    sys_rst_active = 1'b1; base_cnt = BW'(b); mode_ext = m; svc_float = f; svc_in = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_active = 1'b0;
  endtask

  function automatic int self_pt(input int t);
    return t - t / 16;
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, h;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("reset expire", int'(expire), 0);
    chk("reset svc_drive", int'(svc_drive), 0);

    for (int b = 1; b < 16; b++) begin          // R1 sweep
      start(b, 1'b0, 1'b0);
      wait_sig(1'b0, 100, n);
      chk("R1 normal timeout", n, b);
    end

    for (int b = 1; b <= 2; b++) begin          // R2
      start(b, 1'b1, 1'b0);
      wait_sig(1'b0, 2000, n);
      chk("R2 extended timeout", n, b * MULT);
    end

    start(8, 1'b0, 1'b0);                        // R3 rising and falling
    count_sig(1'b0, 5, h);
    chk("R3 no early expire", h, 0);
    @(negedge clk); svc_in = 1'b1;
    wait_sig(1'b0, 100, n);
    chk("R3 rising edge clears", n, 8 + 3);
    @(negedge clk); svc_in = 1'b0;
    wait_sig(1'b0, 100, n);
    chk("R3 falling edge clears", n, 8 + 3);

    start(3, 1'b1, 1'b0);                        // R4
    count_sig(1'b0, 300, h);
    chk("R4 no expire before mode change", h, 0);
    @(negedge clk); mode_ext = 1'b0;
    wait_sig(1'b0, 100, n);
    chk("R4 mode change clears", n, 1 + 3);

    @(negedge clk); sys_rst_active = 1'b1; base_cnt = 4'd5; mode_ext = 1'b0; // R5
    count_sig(1'b0, 50, h);
    chk("R5 no expire in reset", h, 0);
    @(negedge clk); sys_rst_active = 1'b0;
    wait_sig(1'b0, 100, n);
    chk("R5 restart after release", n, 5);

    start(0, 1'b0, 1'b0);                        // R6
    count_sig(1'b0, 600, h);
    chk("R6 zero base normal expire", h, 0);
    start(0, 1'b1, 1'b1);
    count_sig(1'b1, 600, h);
    chk("R6 zero base drive", h, 0);

    start(4, 1'b0, 1'b0);                        // R7
    wait_sig(1'b0, 100, n);
    chk("R7 first expire", n, 4);
    count_sig(1'b0, 50, h);
    chk("R7 saturate single strobe", h, 0);
    @(negedge clk); sys_rst_active = 1'b1;
    repeat (2) @(negedge clk); sys_rst_active = 1'b0;
    wait_sig(1'b0, 100, n);
    chk("R7 repeat after reset", n, 4);

    start(1, 1'b1, 1'b0);                        // R8
    wait_sig(1'b1, 1000, n);
    chk("R8 drive position", n, self_pt(MULT));
    @(posedge clk); #1;
    chk("R8 drive one cycle", int'(svc_drive), 0);
    wait_sig(1'b0, 1000, n);
    chk("R8 expire when not floating", n, MULT - self_pt(MULT) - 1);

    start(1, 1'b1, 1'b1);                        // R9
    wait_sig(1'b1, 1000, n);
    chk("R9 first self-service", n, self_pt(MULT));
    wait_sig(1'b1, 1000, n);
    chk("R9 self-service period", n, self_pt(MULT) + 2);
    count_sig(1'b0, 2000, h);
    chk("R9 never expires", h, 0);

    start(5, 1'b0, 1'b1);                        // R10
    wait_sig(1'b0, 100, n);
    chk("R10 floating normal still expires", n, 5);
    count_sig(1'b1, 40, h);
    chk("R10 no drive in normal", h, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule